// File: doc/BRIEF.md
# Serial EEPROM Address-Width Detector and Word Reader

This block drives a three-wire serial EEPROM: chip select, serial clock, data toward the device and data back from it. Parts of this kind come with different address widths, and the width is not known in advance. After a start pulse the block selects the device and sends the three-bit read command. It then clocks in address bits that are all zero, one at a time. After each one it looks at the returned data line. An undriven line reads high through a pull-up. The device pulls the line low with a dummy zero once it has received its full address, and the number of bits sent up to that point is the address width.

Only a 6-bit width (64 words) and an 8-bit width (256 words) are accepted. Any other count, or eight bits sent with no zero seen, is reported as an error, and the block falls back to 6 bits. Once a result is known, single 16-bit words can be read through a request/ready handshake: the block sends the read command, then the address at the detected width, then clocks in 16 data bits. Every serial bit takes two half-periods of `HALF_CYC` system clocks, with the serial clock low in the first and high in the second.

Top module: `spw_autowidth`

## Requirements
- R1: During and after reset, `ee_cs`, `ee_sk` and `ee_di` are low, `rd_ready`, `aw_valid`, `aw_error` and `rd_valid` are low, and `aw_width` reads 6.
- R2: Every serial bit cell holds `ee_sk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles, with `ee_cs` high and `ee_di` steady across the cell. A transaction's first cell starts in the cycle after the request is accepted. The first three cells carry the read command 1, 1, 0 in that order.
- R3: During detection the address cells drive `ee_di` low. The returned line (after a two-flop synchroniser) is sampled in the last high cycle of each address cell. A low sample after n cells ends the probe, and at most 8 cells are sent.
- R4: A probe that ends on a low sample at n = 6 or n = 8 sets `aw_width` = n, `aw_valid` = 1 and `aw_error` = 0.
- R5: A probe that ends on a low sample at any other n, or that sends 8 cells with no low sample, sets `aw_width` = 6, `aw_error` = 1 and `aw_valid` = 0. A later detection that succeeds clears the error.
- R6: In the cycle after the last cell of a detection or a read, `ee_cs`, `ee_sk` and `ee_di` are all low.
- R7: `rd_ready` is high only when the block is idle and a detection has finished. A `rd_req` seen while `rd_ready` is low, and a `det_start` seen while a transaction runs, leave the serial pins untouched.
- R8: A read sends the command, then the low `aw_width` bits of `rd_addr` with the most significant bit first, and then 16 cells with `ee_di` low. In each of those 16 cells it samples one data bit, most significant bit first.
- R9: `rd_valid` is high for exactly one cycle: the cycle after the last data cell. `rd_data` then holds the assembled word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| det_start | input | 1 | Starts a width detection when the block is idle |
| aw_width | output | 4 | Detected address width, or the 6-bit fallback |
| aw_valid | output | 1 | Last detection found an accepted width |
| aw_error | output | 1 | Last detection failed; the fallback width is in use |
| rd_req | input | 1 | Word-read request, taken when `rd_ready` is high |
| rd_ready | output | 1 | Idle with a detection result available |
| rd_addr | input | 8 | Word address; only the low `aw_width` bits are sent |
| rd_data | output | DATA_W | Word returned by the last read |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as new |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM, pulled high when undriven |

## Verification
If the probe counter or the cell sequencer is wrong, the serial pins show it within one half-period. Examples are an extra or missing address cell, a command bit in the wrong slot, or a select line left high. The bench models the expected pin pattern clock by clock and compares it on every clock, so the first cycle that differs is reported. If the width decision is wrong, it shows in the width, valid and error outputs in the first idle cycle after the probe. Any such error also reaches the reads: the device model answers only to the right command and the right number of address bits, so a shifted address or a short data phase appears in `rd_data` one cycle after the final data cell.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int unsigned OPC_LEN   = 3;
  localparam logic [OPC_LEN-1:0] OPC_READ = 3'b110;
  localparam int unsigned NARROW_AW = 6;
  localparam int unsigned WIDE_AW   = 8;
  localparam int unsigned ADDR_W    = WIDE_AW;
  localparam int unsigned AWC_W     = $clog2(ADDR_W + 1);

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_OPC  = 2'd1,
    SQ_ADR  = 2'd2,
    SQ_DAT  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/spw_sync.sv
module spw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spw_pacer.sv
module spw_pacer #(
  parameter int unsigned HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_PACE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_PACE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/spw_seq.sv
module spw_seq
  import spw_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              do_s,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              run,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic [AWC_W-1:0]  width,
  output logic              width_ok,
  output logic              width_bad,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned TXW = OPC_LEN + ADDR_W;
  localparam int unsigned CW  = $clog2((DATA_W > ADDR_W) ? DATA_W : ADDR_W);

  sq_state_e         st_q, st_d;
  logic              ph_q, ph_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [TXW-1:0]    tx_q, tx_d;
  logic [DATA_W-2:0] rx_q, rx_d;
  logic              det_q, det_d;
  logic              cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic [AWC_W-1:0]  aw_q, aw_d;
  logic              ok_q, ok_d, bad_q, bad_d, done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdv_q, rdv_d;
  logic [AWC_W-1:0]  probe_n;
  logic [AWC_W-1:0]  sh;
  logic              fin;

  assign run       = (st_q != SQ_IDLE);
  assign rd_ready  = (st_q == SQ_IDLE) && done_q;
  assign cs        = cs_q;
  assign sk        = sk_q;
  assign di        = di_q;
  assign width     = aw_q;
  assign width_ok  = ok_q;
  assign width_bad = bad_q;
  assign rd_data   = rdata_q;
  assign rd_valid  = rdv_q;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    det_d   = det_q;
    cs_d    = cs_q;
    sk_d    = sk_q;
    di_d    = di_q;
    aw_d    = aw_q;
    ok_d    = ok_q;
    bad_d   = bad_q;
    done_d  = done_q;
    rdata_d = rdata_q;
    rdv_d   = 1'b0;
    fin     = 1'b0;
    probe_n = AWC_W'(cnt_q) + AWC_W'(1);
    sh      = AWC_W'(ADDR_W) - aw_q;

    if (st_q == SQ_IDLE) begin
      if (start) begin
        st_d   = SQ_OPC;
        ph_d   = 1'b0;
        cnt_d  = '0;
        det_d  = 1'b1;
        tx_d   = {OPC_READ, {ADDR_W{1'b0}}};
        cs_d   = 1'b1;
        sk_d   = 1'b0;
        di_d   = OPC_READ[OPC_LEN-1];
        ok_d   = 1'b0;
        bad_d  = 1'b0;
        done_d = 1'b0;
      end else if (rd_req && done_q) begin
        st_d  = SQ_OPC;
        ph_d  = 1'b0;
        cnt_d = '0;
        det_d = 1'b0;
        tx_d  = {OPC_READ, rd_addr << sh};
        cs_d  = 1'b1;
        sk_d  = 1'b0;
        di_d  = OPC_READ[OPC_LEN-1];
      end
    end else if (tick) begin
      if (!ph_q) begin
        sk_d = 1'b1;
        ph_d = 1'b1;
      end else begin
        sk_d = 1'b0;
        ph_d = 1'b0;
        tx_d = tx_q << 1;
        di_d = tx_q[TXW-2];
        case (st_q)
          SQ_OPC: begin
            if (cnt_q == CW'(OPC_LEN - 1)) begin
              st_d  = SQ_ADR;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          SQ_ADR: begin
            if (det_q) begin
              if (!do_s || (cnt_q == CW'(ADDR_W - 1))) begin
                fin    = 1'b1;
                done_d = 1'b1;
                if (!do_s && ((probe_n == AWC_W'(NARROW_AW)) ||
                              (probe_n == AWC_W'(WIDE_AW)))) begin
                  aw_d = probe_n;
                  ok_d = 1'b1;
                end else begin
                  aw_d  = AWC_W'(NARROW_AW);
                  bad_d = 1'b1;
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else if (probe_n == aw_q) begin
              st_d  = SQ_DAT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          SQ_DAT: begin
            rx_d = {rx_q[DATA_W-3:0], do_s};
            if (cnt_q == CW'(DATA_W - 1)) begin
              fin     = 1'b1;
              rdata_d = {rx_q, do_s};
              rdv_d   = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: fin = 1'b1;
        endcase
        if (fin) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
          cs_d  = 1'b0;
          sk_d  = 1'b0;
          di_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      ph_q    <= 1'b0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      det_q   <= 1'b0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      aw_q    <= AWC_W'(NARROW_AW);
      ok_q    <= 1'b0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      rdv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      det_q   <= det_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      di_q    <= di_d;
      aw_q    <= aw_d;
      ok_q    <= ok_d;
      bad_q   <= bad_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      rdv_q   <= rdv_d;
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sk_q |-> cs_q); // R2
  AST_DI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_q && $past(sk_q)) |-> $stable(di_q)); // R2
  AST_PROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ADR && det_q) |-> !di_q); // R3
  AST_OK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> ((aw_q == AWC_W'(NARROW_AW)) || (aw_q == AWC_W'(WIDE_AW))) && !bad_q); // R4
  AST_BAD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> (aw_q == AWC_W'(NARROW_AW))); // R5
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE) |-> (!cs_q && !sk_q && !di_q)); // R6
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !cs_q); // R7
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |=> !rdv_q); // R9
endmodule

// File: rtl/spw_autowidth.sv
module spw_autowidth
  import spw_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 50,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_start,
  output logic [AWC_W-1:0]  aw_width,
  output logic              aw_valid,
  output logic              aw_error,
  input  logic              rd_req,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  logic rst_n_int;
  logic do_s;
  logic run;
  logic tick;

  spw_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  spw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_do_sync (
    .clk(clk), .rst_n(rst_n_int), .d(ee_do), .q(do_s)
  );

  spw_pacer #(.HALF_CYC(HALF_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n_int), .run(run), .tick(tick)
  );

  spw_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .do_s(do_s),
    .start(det_start), .rd_req(rd_req), .rd_addr(rd_addr),
    .run(run), .cs(ee_cs), .sk(ee_sk), .di(ee_di),
    .width(aw_width), .width_ok(aw_valid), .width_bad(aw_error),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/spw_autowidth_test.sv
module spw_autowidth_test;
  localparam int HC = 4;

  logic        clk;
  logic        rst_n;
  logic        det_start;
  logic [3:0]  aw_width;
  logic        aw_valid;
  logic        aw_error;
  logic        rd_req;
  logic        rd_ready;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  spw_autowidth #(.HALF_CYC(HC), .SYNC_STAGES(2), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .det_start(det_start),
    .aw_width(aw_width), .aw_valid(aw_valid), .aw_error(aw_error),
    .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] dev_word(input int a);
    return 16'((a * 32'h2B1D) ^ 32'h9C36);
  endfunction

  // ---------------- EEPROM device model ----------------
  int dev_w = 99;
  int sk_n;
  logic [2:0] d_op;
  int d_adr;
  logic [15:0] d_word;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      sk_n = 0; d_op = 3'b000; d_adr = 0; ee_do = 1'b1;
    end else begin
      sk_n++;
      if (sk_n <= 3) d_op = {d_op[1:0], ee_di};
      else if (sk_n <= 3 + dev_w) d_adr = (d_adr << 1) | int'(ee_di);
      if (d_op == 3'b110 && sk_n == 3 + dev_w) ee_do = 1'b0;
      else if (d_op == 3'b110 && sk_n > 3 + dev_w && sk_n <= 3 + dev_w + 16) begin
        d_word = dev_word(d_adr);
        ee_do = d_word[15 - (sk_n - 4 - dev_w)];
      end else ee_do = 1'b1;
    end
  end

  // ---------------- reference model ----------------
  int q[$];
  bit mon_on = 0;
  bit model_done = 0;
  int model_w = 6;
  bit model_ok = 0, model_bad = 0;
  bit pend_det = 0, pend_rd = 0, exp_rdv = 0;
  int pend_w; bit pend_ok, pend_bad;
  logic [15:0] pend_data, exp_data;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_cell(input bit b);
    for (int i = 0; i < HC; i++) q.push_back(int'({2'b10, b}));
    for (int i = 0; i < HC; i++) q.push_back(int'({2'b11, b}));
  endtask

  task automatic push_opc();
    push_cell(1'b1); push_cell(1'b1); push_cell(1'b0);
  endtask

  task automatic push_det();
    int p;
    p = (dev_w >= 1 && dev_w <= 8) ? dev_w : 8;
    push_opc();
    for (int i = 0; i < p; i++) push_cell(1'b0);
    if (dev_w == 6 || dev_w == 8) begin pend_w = dev_w; pend_ok = 1; pend_bad = 0; end
    else begin pend_w = 6; pend_ok = 0; pend_bad = 1; end
    model_done = 0; model_ok = 0; model_bad = 0; pend_det = 1;
  endtask

  task automatic push_rd(input logic [7:0] a);
    int m;
    push_opc();
    for (int i = model_w - 1; i >= 0; i--) push_cell(a[i]);
    for (int i = 0; i < 16; i++) push_cell(1'b0);
    m = int'(a) & ((1 << model_w) - 1);
    pend_data = dev_word(m);
    pend_rd = 1;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0) begin
        int e;
        e = q.pop_front();
        chk({29'b0, ee_cs, ee_sk, ee_di}, 32'(e), "R2/R3/R8 serial pins");
        chk({31'b0, rd_ready}, 0, "R7 ready while busy");
        chk({31'b0, rd_valid}, 0, "R9 valid while busy");
        if (q.size() == 0) begin
          if (pend_det) begin
            model_w = pend_w; model_ok = pend_ok; model_bad = pend_bad;
            model_done = 1; pend_det = 0;
          end
          if (pend_rd) begin exp_rdv = 1; exp_data = pend_data; pend_rd = 0; end
        end
      end else begin
        chk({29'b0, ee_cs, ee_sk, ee_di}, 0, "R6 pins idle");
        chk({31'b0, rd_ready}, {31'b0, model_done}, "R7 ready");
        chk({28'b0, aw_width}, 32'(model_w), "R4/R5 width");
        chk({31'b0, aw_valid}, {31'b0, model_ok}, "R4 valid");
        chk({31'b0, aw_error}, {31'b0, model_bad}, "R5 error");
        chk({31'b0, rd_valid}, {31'b0, exp_rdv}, "R9 valid pulse");
        if (exp_rdv) chk({16'b0, rd_data}, {16'b0, exp_data}, "R8 read data");
        exp_rdv = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_detect(input int w);
    dev_w = w;
    @(negedge clk); #1;
    det_start = 1'b1; push_det();
    @(negedge clk); #1;
    det_start = 1'b0;
    wait_idle();
  endtask

  task automatic issue_read(input logic [7:0] a);
    forever begin
      @(negedge clk); #1;
      if (rd_ready) break;
    end
    rd_req = 1'b1; rd_addr = a; push_rd(a);
    @(negedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    issue_read(a);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; det_start = 1'b0; rd_req = 1'b0; rd_addr = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({29'b0, ee_cs, ee_sk, ee_di}, 0, "R1 pins in reset");
    chk({31'b0, rd_ready}, 0, "R1 ready in reset");
    chk({28'b0, aw_width}, 6, "R1 width in reset");
    chk({30'b0, aw_valid, aw_error}, 0, "R1 flags in reset");
    chk({31'b0, rd_valid}, 0, "R1 valid in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    repeat (3) @(negedge clk);
    // R7 request before detection is held off
    #1 rd_req = 1'b1; rd_addr = 8'h15;
    @(negedge clk); #1 rd_req = 1'b0;
    repeat (10) @(negedge clk);
    // R4 6-bit device
    do_detect(6);
    do_read(8'h05);
    do_read(8'h3F);
    do_read(8'hEA);   // R8 upper bits dropped
    // R4 8-bit device
    do_detect(8);
    do_read(8'hA5);
    do_read(8'hFF);
    // R7 start and request while busy are ignored
    issue_read(8'h00);
    repeat (5) @(negedge clk);
    #1 det_start = 1'b1; rd_req = 1'b1; rd_addr = 8'h77;
    @(negedge clk); #1 det_start = 1'b0; rd_req = 1'b0;
    wait_idle();
    // R5 strange sizes and absent device
    do_detect(7);
    do_detect(4);
    do_detect(99);
    do_read(8'h21);   // fallback width read, no device answers
    // R5 recovery
    do_detect(8);
    do_read(8'h3C);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // fallback read with no device: data all ones
  always @(negedge clk) if (pend_rd && dev_w == 99) pend_data = 16'hFFFF;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule